// File: doc/BRIEF.md
# Composite Fractional Clock Divider

The block divides a fast master clock by a ratio chosen with three static control bits: a mode bit that adds a factor of one and a half, and two divider bits that each add a factor of two. Several bit patterns give the same ratio, so the block can produce divide-by-1, 1.5, 2, 3 or 4. The ratios 1.5 and 3 are not whole numbers of input periods. For these ratios the block works in half input periods and uses both edges of the input clock, so every output period has exactly the requested length.

Internally the output period is a frame of 2 x ratio half-slots. The output is high for the first floor(frame/2) half-slots and low for the rest. A posedge sequencer tracks the half-slot position and sets the output level for each half. A negedge register and an XOR rebuild the output with no clock multiplexer, and divide-by-1 uses this same path. The control bits are read only at a frame start, which is a rising output edge that follows a complete low phase. A ratio change therefore never cuts a period short. The one reserved pattern holds the output low and raises a flag. An asynchronous reset clears all state and drives the output low.

Top module: `clkdiv_frac`

## Requirements
- R1: Control {mode_x15, div_sel[1], div_sel[0]} = 000 gives divide-by-1: period 2 half-slots, high for 1 (the output follows the input clock).
- R2: Control 100 gives divide-by-1.5: output period 3 half input periods, high for the first 1 half-slot.
- R3: Controls 001 and 010 both give divide-by-2: period 4 half-slots, high for 2.
- R4: Controls 101 and 110 both give divide-by-3: period 6 half-slots, high for 3 (exact 50% duty).
- R5: Control 011 gives divide-by-4: period 8 half-slots, high for 4.
- R6: Control 111 is reserved. Once it takes effect, clk_out stays low and rsv_flag is 1. For every other control value rsv_flag is 0.
- R7: A new control value takes effect only at a frame start. The output is low in the half-slot just before any frame start, and every complete output period matches either the old ratio or the new one exactly.
- R8: While arst is high, clk_out and rsv_flag are 0. With a valid control, the first high phase begins at the first rising input edge after arst falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast master clock; both edges are used |
| arst | input | 1 | Asynchronous reset, active high |
| mode_x15 | input | 1 | Adds a factor of 1.5 to the division when high |
| div_sel | input | 2 | Each high bit adds a factor of 2 to the division |
| clk_out | output | 1 | Divided clock |
| rsv_flag | output | 1 | High while the reserved control value is in effect |

## Verification
The embedded assertions check the sequencing rules on every cycle. The active ratio may change only when the half-slot position is zero, and the position always stays inside the active frame. The output must be low in the half-slot before every frame start. The reserved state must force both level requests low and hold the output low. The actual period and high-time lengths of each ratio, the matching of redundant patterns, the old-or-new shape of every period during a change, and the reset and first-edge behaviour are shown only by the bench scenarios, which measure the output half-slot by half-slot.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CFG_W  = 3;
  localparam int HALF_W = 4;

  typedef logic [HALF_W-1:0] halves_t;

  // all control bits high is the unusable pattern
  function automatic logic cfg_reserved(logic [CFG_W-1:0] c);
    return &c;
  endfunction

  // frame length in half input periods; zero means "hold low"
  function automatic halves_t frame_halves(logic [CFG_W-1:0] c);
    logic [1:0] k;
    halves_t    base;
    k    = {1'b0, c[1]} + {1'b0, c[0]};
    base = halves_t'(2) << k;
    if (cfg_reserved(c)) return '0;
    if (c[2]) return base + (base >> 1);
    return base;
  endfunction

  // the first floor(len/2) half-slots of a frame are high
  function automatic logic slot_level(halves_t s, halves_t len);
    return (s < (len >> 1));
  endfunction

  function automatic halves_t wrap_add(halves_t p, halves_t inc, halves_t len);
    halves_t s;
    if (len == '0) return '0;
    s = p + inc;
    if (s >= len) s = s - len;
    return s;
  endfunction
endpackage

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             arst,
  input  logic [CFG_W-1:0] cfg,
  output logic             lvl_a,
  output logic             lvl_b,
  output logic             rsv_q,
  output halves_t          pos_q,
  output halves_t          act_q
);
  logic    at_frame;
  halves_t len_use;
  halves_t slot_b;
  halves_t pos_nx;

  assign at_frame = (pos_q == '0);
  assign len_use  = at_frame ? frame_halves(cfg) : act_q;
  assign lvl_a    = slot_level(pos_q, len_use);
  assign slot_b   = wrap_add(pos_q, halves_t'(1), len_use);
  assign pos_nx   = wrap_add(pos_q, halves_t'(2), len_use);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      pos_q <= '0;
      act_q <= '0;
      lvl_b <= 1'b0;
      rsv_q <= 1'b0;
    end else begin
      pos_q <= pos_nx;
      act_q <= len_use;
      lvl_b <= slot_level(slot_b, len_use);
      if (at_frame) rsv_q <= cfg_reserved(cfg);
    end
  end

  // R7: the active frame length moves only at a frame start
  p_ratio_at_frame_r7: assert property (@(posedge clk) disable iff (arst)
    (act_q != $past(act_q)) |-> ($past(pos_q) == '0));

  // R7: the position never leaves the active frame
  p_pos_in_frame_r7: assert property (@(posedge clk) disable iff (arst)
    (act_q != '0) |-> (pos_q < act_q));

  // R6: the reserved state requests no high half-slot
  p_rsv_quiet_r6: assert property (@(posedge clk) disable iff (arst)
    rsv_q |-> (!lvl_b && act_q == '0));
endmodule

// File: rtl/clkdiv_edges.sv
module clkdiv_edges (
  input  logic clk,
  input  logic arst,
  input  logic lvl_a,
  input  logic lvl_b,
  output logic clk_o
);
  logic rise_q;
  logic fall_q;

  // each register toggles the XOR so the output takes the requested level
  always_ff @(posedge clk or posedge arst) begin
    if (arst) rise_q <= 1'b0;
    else      rise_q <= lvl_a ^ fall_q;
  end

  always_ff @(negedge clk or posedge arst) begin
    if (arst) fall_q <= 1'b0;
    else      fall_q <= lvl_b ^ rise_q;
  end

  assign clk_o = rise_q ^ fall_q;
endmodule

// File: rtl/clkdiv_frac.sv
module clkdiv_frac
  import clkdiv_pkg::*;
(
  input  logic       clk_in,
  input  logic       arst,
  input  logic       mode_x15,
  input  logic [1:0] div_sel,
  output logic       clk_out,
  output logic       rsv_flag
);
  logic             lvl_a;
  logic             lvl_b;
  logic             rsv_q;
  halves_t          pos_q;
  halves_t          act_q;
  logic [CFG_W-1:0] cfg;

  assign cfg = {mode_x15, div_sel};

  clkdiv_seq u_seq (
    .clk   (clk_in),
    .arst  (arst),
    .cfg   (cfg),
    .lvl_a (lvl_a),
    .lvl_b (lvl_b),
    .rsv_q (rsv_q),
    .pos_q (pos_q),
    .act_q (act_q)
  );

  clkdiv_edges u_edges (
    .clk   (clk_in),
    .arst  (arst),
    .lvl_a (lvl_a),
    .lvl_b (lvl_b),
    .clk_o (clk_out)
  );

  assign rsv_flag = rsv_q;

  // R7: the half-slot before a frame start is low, so no runt can appear
  p_low_before_frame_r7: assert property (@(posedge clk_in) disable iff (arst)
    (pos_q == '0 && act_q != '0 && $past(act_q) == act_q) |-> !clk_out);

  // R6: a settled reserved state keeps the output low
  p_rsv_out_low_r6: assert property (@(posedge clk_in) disable iff (arst)
    (rsv_flag && $past(rsv_flag)) |-> !clk_out);

  // R8: output and flag are low while reset is applied
  always_comb begin
    if (arst) begin
      p_reset_low_r8: assert (!clk_out && !rsv_flag);
    end
  end
endmodule

// File: tb/clkdiv_frac_tb_top.sv
`timescale 1ns/100ps
module clkdiv_frac_tb_top;
  logic       clk = 1'b0;
  logic       arst = 1'b1;
  logic       mode_x15 = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       clk_out;
  logic       rsv_flag;

  int errors = 0;
  int checks = 0;

  typedef struct { int per; int hi; string req; } exp_t;
  exp_t sbq[$];

  bit watch = 1'b0;
  int alw_per[2];
  int alw_hi[2];
  int cur_per = 0;

  always #2 clk = ~clk;

  clkdiv_frac dut_i (
    .clk_in   (clk),
    .arst     (arst),
    .mode_x15 (mode_x15),
    .div_sel  (div_sel),
    .clk_out  (clk_out),
    .rsv_flag (rsv_flag)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected frame in half-slots, computed as ratio*2
  function automatic int exp_per(logic [2:0] c);
    int r;
    r = 2;
    if (c[0]) r = r * 2;
    if (c[1]) r = r * 2;
    if (c[2]) r = r + r / 2;
    return r;
  endfunction

  // monitor: sample every half-slot, measure rise-to-rise periods
  initial begin
    logic prev;
    bit   seen;
    int   per, hi;
    prev = 1'b0; seen = 1'b0; per = 0; hi = 0;
    forever begin
      @(clk);
      #1;
      if (arst || rsv_flag) begin
        seen = 1'b0;
        prev = clk_out;
      end else begin
        if (clk_out && !prev) begin
          if (seen) begin
            if (sbq.size() > 0) begin
              exp_t e;
              e = sbq.pop_front();
              chk(per == e.per, e.req, "period halves", per, e.per);
              chk(hi == e.hi, e.req, "high halves", hi, e.hi);
            end else if (watch) begin
              bit ok;
              ok = (per == alw_per[0] && hi == alw_hi[0]) ||
                   (per == alw_per[1] && hi == alw_hi[1]);
              chk(ok, "R7", "period during change", per, alw_per[1]);
            end
          end
          seen = 1'b1;
          per = 1;
          hi = 1;
        end else if (seen) begin
          per++;
          if (clk_out) hi++;
        end
        prev = clk_out;
      end
    end
  end

  // driver: apply a control value, then queue the expected periods
  task automatic run_cfg(logic [2:0] c, int nper, string req);
    int np;
    np = exp_per(c);
    alw_per[0] = cur_per; alw_hi[0] = cur_per / 2;
    alw_per[1] = np;      alw_hi[1] = np / 2;
    watch = 1'b1;
    @(negedge clk);
    #0.5;
    {mode_x15, div_sel} = c;
    repeat (12) @(posedge clk);
    for (int i = 0; i < nper; i++) sbq.push_back('{np, np / 2, req});
    while (sbq.size() > 0) @(posedge clk);
    cur_per = np;
    chk(rsv_flag == 1'b0, "R6", "flag on valid setting", rsv_flag, 0);
  endtask

  task automatic run_reserved();
    int highs;
    watch = 1'b0;
    @(negedge clk);
    #0.5;
    {mode_x15, div_sel} = 3'b111;
    repeat (12) @(posedge clk);
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      @(clk);
      #1;
      if (clk_out) highs++;
    end
    chk(highs == 0, "R6", "high half-slots when reserved", highs, 0);
    chk(rsv_flag == 1'b1, "R6", "flag when reserved", rsv_flag, 1);
    cur_per = 0;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(clk_out == 1'b0, "R8", "clk_out in reset", clk_out, 0);
    chk(rsv_flag == 1'b0, "R8", "rsv_flag in reset", rsv_flag, 0);
    @(negedge clk);
    #0.5;
    arst = 1'b0;
    @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R8", "first high after release", clk_out, 1);
    cur_per = 2;

    run_cfg(3'b000, 6, "R1");
    run_cfg(3'b100, 6, "R2");
    run_cfg(3'b001, 4, "R3");
    run_cfg(3'b010, 4, "R3");
    run_cfg(3'b101, 4, "R4");
    run_cfg(3'b110, 4, "R4");
    run_cfg(3'b011, 4, "R5");
    run_cfg(3'b100, 4, "R2");
    run_cfg(3'b011, 3, "R5");
    run_reserved();
    run_cfg(3'b100, 4, "R2");
    run_cfg(3'b000, 4, "R1");
    run_cfg(3'b101, 3, "R4");

    // R8: reset in mid-frame forces the output low again
    @(negedge clk);
    #0.5;
    arst = 1'b1;
    #1;
    chk(clk_out == 1'b0, "R8", "clk_out after async reset", clk_out, 0);
    @(negedge clk);
    #0.5;
    arst = 1'b0;
    @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R8", "first high after second release", clk_out, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule